// File: doc/BRIEF.md
# Clock Ratio Change Sequencer

This block manages the ratio settings of a core clock and a peripheral clock that are derived from a PLL multiplier followed by two dividers. Software writes a frequency control word. The word holds a multiplier code, a core divider code and a peripheral divider code. The block drives the multiplier select and the two divider selects. From the reference clock it also produces one clock-enable pulse train for the core and one for the peripheral.

If a write leaves the multiplier unchanged, it is a divider-only change and takes effect on the next cycle. If a write changes the multiplier, the block opens a lock-settling wait. The wait borrows an 8-bit up-counter that software has loaded beforehand, along with its prescaler select. During the wait the processor stall is high and both clock enables are held low. The external clock output keeps toggling. When the counter overflows, the new multiplier and both dividers take effect together, the stall is released and the counter stops.

A write that asks for a divider combination not allowed with its multiplier is refused. The refused write raises an error flag and changes nothing.

Top module: `clkseq_top`

## Requirements
- R1: After reset the multiplier select is 00, the core divider select is 00, the peripheral divider select is 011, and stall, busy, error and the counter value are all 0.
- R2: The frequency control word places the multiplier code in bits [6:5], giving factor code+1. It places the core divider code in bits [4:3] and the peripheral divider code in bits [2:0], each giving divisor code+1.
- R3: A legal write whose multiplier code equals the current one updates the divider selects on the next cycle without stalling. Each enable is high in the first cycle after the write and then once every divisor cycles.
- R4: A legal write with a new multiplier code holds stall high, starting in the next cycle, for exactly 2^(k+1)*(256-L) cycles. Here k is the prescaler select and L is the loaded start count.
- R5: While stall is high, the core enable and the peripheral enable are both 0.
- R6: The external clock output toggles on every reference clock cycle, including during the settling wait.
- R7: During the wait the selects keep their old values. The multiplier and both dividers from the starting write appear together in the cycle in which stall falls.
- R8: At the end of the wait the counter reads 0 and no longer counts.
- R9: Frequency writes and counter setup writes that arrive during the wait are ignored.
- R10: A combination is legal only when the core divider code is at most the multiplier code and the peripheral divider code is at least the core divider code. An illegal write sets the error flag on the next cycle and leaves selects and stall unchanged. The next accepted write clears the flag.
- R11: A counter setup write while idle loads the start count, which then reads back on the counter value output on the next cycle.
- R12: The busy output equals stall in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low reset |
| frq_we_i | input | 1 | Frequency control word write strobe |
| frq_wdata_i | input | 7 | Frequency control word |
| tmr_we_i | input | 1 | Counter setup write strobe |
| tmr_sel_i | input | 3 | Prescaler select k, divide by 2^(k+1) |
| tmr_load_i | input | 8 | Counter start count |
| core_en_o | output | 1 | Core clock enable |
| per_en_o | output | 1 | Peripheral clock enable |
| mult_sel_o | output | 2 | Active multiplier code |
| core_div_o | output | 2 | Active core divider code |
| per_div_o | output | 3 | Active peripheral divider code |
| stall_o | output | 1 | Processor stall during settling |
| busy_o | output | 1 | Settling wait in progress |
| err_o | output | 1 | Last write was an illegal combination |
| ext_clk_o | output | 1 | Free-running external clock toggle |
| cnt_o | output | 8 | Settling counter value |

## Verification
Two events can fall in the same cycle. One is a new frequency write or a counter setup write, and the other is the counting of a settling wait that is still open. The bench provokes this by driving both write strobes at once in the middle of a wait. It then judges the outcome by three results: the wait ends after the original count, the selects come from the first write, and the counter reads 0 and not the value written late. A second coincidence is the overflow, which lands on the same edge as the enable restart and the release of the stall. The bench checks it by sampling the enable pattern in the first cycle after the stall falls.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
   localparam int MUL_W  = 2;
   localparam int CDIV_W = 2;
   localparam int PDIV_W = 3;
   localparam int FRQ_W  = MUL_W + CDIV_W + PDIV_W;

   typedef struct packed {
      logic [MUL_W-1:0]  mul;
      logic [CDIV_W-1:0] cdiv;
      logic [PDIV_W-1:0] pdiv;
   } frq_t;

   typedef enum logic [1:0] {
      WR_NONE,
      WR_DIV,
      WR_MUL,
      WR_BAD
   } wr_kind_e;

   // core divisor may not exceed the multiplier factor, and the
   // peripheral divisor may not be finer than the core divisor
   function automatic logic combo_ok(input frq_t f);
      return (int'(f.cdiv) <= int'(f.mul)) && (int'(f.pdiv) >= int'(f.cdiv));
   endfunction
endpackage

// File: rtl/clkseq_ratio_ctrl.sv
module clkseq_ratio_ctrl
   import clkseq_pkg::*;
#(
   parameter frq_t RST_FRQ = '{mul: '0, cdiv: '0, pdiv: 3'd3}
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic wr_en_i,
   input  frq_t wr_data_i,
   input  logic ovf_i,
   output frq_t cur_o,
   output logic stall_o,
   output logic err_o,
   output logic start_o,
   output logic apply_o
);
   frq_t     cur_q, pend_q;
   logic     stall_q, err_q;
   wr_kind_e kind;
   logic     release_w;

   always_comb begin
      if (!wr_en_i || stall_q)
         kind = WR_NONE;
      else if (!combo_ok(wr_data_i))
         kind = WR_BAD;
      else if (wr_data_i.mul == cur_q.mul)
         kind = WR_DIV;
      else
         kind = WR_MUL;
   end

   assign release_w = stall_q && ovf_i;
   assign start_o   = (kind == WR_MUL);
   assign apply_o   = (kind == WR_DIV) || release_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q   <= RST_FRQ;
         pend_q  <= RST_FRQ;
         stall_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (kind)
            WR_DIV: begin
               cur_q <= wr_data_i;
               err_q <= 1'b0;
            end
            WR_MUL: begin
               pend_q  <= wr_data_i;
               stall_q <= 1'b1;
               err_q   <= 1'b0;
            end
            WR_BAD:  err_q <= 1'b1;
            default: ;
         endcase
         if (release_w) begin
            cur_q   <= pend_q;
            stall_q <= 1'b0;
         end
      end
   end

   assign cur_o   = cur_q;
   assign stall_o = stall_q;
   assign err_o   = err_q;
endmodule

// File: rtl/clkseq_settle_timer.sv
module clkseq_settle_timer #(
   parameter int CNT_W = 8,
   parameter int SEL_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cfg_we_i,
   input  logic [SEL_W-1:0] cfg_sel_i,
   input  logic [CNT_W-1:0] cfg_load_i,
   input  logic             start_i,
   output logic             run_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o
);
   localparam int PCW = 1 << SEL_W;

   logic [SEL_W-1:0] sel_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PCW-1:0]   pc_q;
   logic [PCW:0]     lim;
   logic             run_q, tick;

   always_comb lim = (PCW+1)'((64'd1 << (int'(sel_q) + 1)) - 64'd1);

   assign tick  = run_q && ({1'b0, pc_q} == lim);
   assign ovf_o = tick && (&cnt_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sel_q <= '0;
         cnt_q <= '0;
         pc_q  <= '0;
         run_q <= 1'b0;
      end else if (!run_q) begin
         if (cfg_we_i) begin
            sel_q <= cfg_sel_i;
            cnt_q <= cfg_load_i;
         end
         if (start_i) begin
            run_q <= 1'b1;
            pc_q  <= '0;
         end
      end else begin
         if (tick) begin
            pc_q  <= '0;
            cnt_q <= cnt_q + 1'b1;
         end else begin
            pc_q <= pc_q + 1'b1;
         end
         if (ovf_o) run_q <= 1'b0;
      end
   end

   assign run_o = run_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/clkseq_en_gen.sv
module clkseq_en_gen #(
   parameter int W = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] div_i,
   input  logic         hold_i,
   input  logic         restart_i,
   output logic         en_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (hold_i || restart_i || (cnt_q >= div_i))
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign en_o = !hold_i && (cnt_q == '0);
endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
   import clkseq_pkg::*;
#(
   parameter int          CNT_W    = 8,
   parameter int          SEL_W    = 3,
   parameter logic [1:0]  RST_MUL  = 2'd0,
   parameter logic [1:0]  RST_CDIV = 2'd0,
   parameter logic [2:0]  RST_PDIV = 3'd3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              frq_we_i,
   input  logic [6:0]        frq_wdata_i,
   input  logic              tmr_we_i,
   input  logic [SEL_W-1:0]  tmr_sel_i,
   input  logic [CNT_W-1:0]  tmr_load_i,
   output logic              core_en_o,
   output logic              per_en_o,
   output logic [1:0]        mult_sel_o,
   output logic [1:0]        core_div_o,
   output logic [2:0]        per_div_o,
   output logic              stall_o,
   output logic              busy_o,
   output logic              err_o,
   output logic              ext_clk_o,
   output logic [CNT_W-1:0]  cnt_o
);
   localparam frq_t RST_FRQ = '{mul: RST_MUL, cdiv: RST_CDIV, pdiv: RST_PDIV};

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("clkseq_top: CNT_W out of range");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("clkseq_top: SEL_W out of range");
   end
   if (FRQ_W != 7) begin : g_bad_frq
      $error("clkseq_top: control word width mismatch");
   end

   frq_t cur;
   logic start, apply, ovf, run, stall;

   clkseq_ratio_ctrl #(.RST_FRQ(RST_FRQ)) u_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (frq_we_i),
      .wr_data_i (frq_t'(frq_wdata_i)),
      .ovf_i     (ovf),
      .cur_o     (cur),
      .stall_o   (stall),
      .err_o     (err_o),
      .start_o   (start),
      .apply_o   (apply)
   );

   clkseq_settle_timer #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_tmr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (tmr_we_i),
      .cfg_sel_i  (tmr_sel_i),
      .cfg_load_i (tmr_load_i),
      .start_i    (start),
      .run_o      (run),
      .cnt_o      (cnt_o),
      .ovf_o      (ovf)
   );

   clkseq_en_gen #(.W(CDIV_W)) u_core_en (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .div_i     (cur.cdiv),
      .hold_i    (stall),
      .restart_i (apply),
      .en_o      (core_en_o)
   );

   clkseq_en_gen #(.W(PDIV_W)) u_per_en (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .div_i     (cur.pdiv),
      .hold_i    (stall),
      .restart_i (apply),
      .en_o      (per_en_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ext_clk_o <= 1'b0;
      else         ext_clk_o <= ~ext_clk_o;
   end

   assign mult_sel_o = cur.mul;
   assign core_div_o = cur.cdiv;
   assign per_div_o  = cur.pdiv;
   assign stall_o    = stall;
   assign busy_o     = run;
endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             core_en_o,
   input logic             per_en_o,
   input logic [1:0]       mult_sel_o,
   input logic [1:0]       core_div_o,
   input logic [2:0]       per_div_o,
   input logic             stall_o,
   input logic             busy_o,
   input logic             err_o,
   input logic             ext_clk_o,
   input logic [CNT_W-1:0] cnt_o
);
   logic past_ok;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) past_ok <= 1'b0;
      else         past_ok <= 1'b1;
   end

   a_r5_enables_low_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_o |-> (!core_en_o && !per_en_o));

   a_r6_ext_toggles: assert property (@(posedge clk_i) disable iff (!rst_ni)
      past_ok |-> (ext_clk_o != $past(ext_clk_o)));

   a_r7_codes_frozen_in_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $past(stall_o) && stall_o) |->
         $stable({mult_sel_o, core_div_o, per_div_o}));

   a_r8_count_zero_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $fell(stall_o)) |-> (cnt_o == '0));

   a_r10_bad_write_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (past_ok && $rose(err_o)) |->
         ($stable({mult_sel_o, core_div_o, per_div_o}) && !$rose(stall_o)));

   a_r12_busy_tracks_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o == stall_o);
endmodule

bind clkseq_top clkseq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .core_en_o  (core_en_o),
   .per_en_o   (per_en_o),
   .mult_sel_o (mult_sel_o),
   .core_div_o (core_div_o),
   .per_div_o  (per_div_o),
   .stall_o    (stall_o),
   .busy_o     (busy_o),
   .err_o      (err_o),
   .ext_clk_o  (ext_clk_o),
   .cnt_o      (cnt_o)
);

// File: tb/sim_clkseq_top.sv
`timescale 1ns/1ps
module sim_clkseq_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frq_we = 1'b0;
   logic [6:0] frq_wdata = '0;
   logic       tmr_we = 1'b0;
   logic [2:0] tmr_sel = '0;
   logic [7:0] tmr_load = '0;
   logic       core_en, per_en, stall, busy, err, ext_clk;
   logic [1:0] mult_sel, core_div;
   logic [2:0] per_div;
   logic [7:0] cnt;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2 clk = ~clk;

   clkseq_top u0 (
      .clk_i (clk), .rst_ni (rst_n),
      .frq_we_i (frq_we), .frq_wdata_i (frq_wdata),
      .tmr_we_i (tmr_we), .tmr_sel_i (tmr_sel), .tmr_load_i (tmr_load),
      .core_en_o (core_en), .per_en_o (per_en),
      .mult_sel_o (mult_sel), .core_div_o (core_div), .per_div_o (per_div),
      .stall_o (stall), .busy_o (busy), .err_o (err),
      .ext_clk_o (ext_clk), .cnt_o (cnt)
   );

   // {wdata[6:0], stall cycles[7:0], expected selects[6:0], expected err}
   // timer is reloaded with k=0, L=8'hFE before each entry: 2*2 = 4 cycles
   localparam logic [22:0] VEC [7] = '{
      {7'h05, 8'd0, 7'h05, 1'b0},
      {7'h2B, 8'd4, 7'h2B, 1'b0},
      {7'h33, 8'd0, 7'h2B, 1'b1},
      {7'h7F, 8'd4, 7'h7F, 1'b0},
      {7'h71, 8'd0, 7'h7F, 1'b1},
      {7'h6A, 8'd0, 7'h6A, 1'b0},
      {7'h03, 8'd4, 7'h03, 1'b0}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic write_frq(input logic [6:0] d);
      @(negedge clk);
      frq_we = 1'b1; frq_wdata = d;
      @(negedge clk);
      frq_we = 1'b0;
   endtask

   task automatic load_tmr(input logic [2:0] k, input logic [7:0] l);
      @(negedge clk);
      tmr_we = 1'b1; tmr_sel = k; tmr_load = l;
      @(negedge clk);
      tmr_we = 1'b0;
   endtask

   task automatic count_stall(output int n);
      n = 0;
      while (stall && n < 5000) begin
         if (busy != stall) chk("R12 busy vs stall", busy, stall);
         n++;
         @(negedge clk);
      end
   endtask

   function automatic int sel_word();
      return int'({mult_sel, core_div, per_div});
   endfunction

   initial begin
      int n;
      logic e0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 selects", sel_word(), 7'h03);
      chk("R1 stall", stall, 0);
      chk("R1 busy", busy, 0);
      chk("R1 err", err, 0);
      chk("R1 count", cnt, 0);

      // table walk: R2 encoding, R3/R4 paths, R10 legality
      foreach (VEC[i]) begin
         load_tmr(3'd0, 8'hFE);
         write_frq(VEC[i][22:16]);
         count_stall(n);
         chk($sformatf("R4 stall length vec%0d", i), n, int'(VEC[i][15:8]));
         chk($sformatf("R2 R7 selects vec%0d", i), sel_word(), int'(VEC[i][7:1]));
         chk($sformatf("R10 err vec%0d", i), err, int'(VEC[i][0]));
      end

      // R11 counter load while idle
      load_tmr(3'd0, 8'hA5);
      chk("R11 loaded count", cnt, 8'hA5);

      // R3 divider-only change: peripheral /3, core /1
      write_frq(7'h02);
      chk("R3 no stall", stall, 0);
      for (int c = 0; c < 6; c++) begin
         chk($sformatf("R3 per_en cycle%0d", c), per_en, (c % 3 == 0) ? 1 : 0);
         chk($sformatf("R3 core_en cycle%0d", c), core_en, 1);
         @(negedge clk);
      end

      // R5 R6 R7 R9 R8 during a settling wait
      load_tmr(3'd0, 8'hFE);
      write_frq(7'h2B);
      chk("R4 stall starts", stall, 1);
      chk("R12 busy starts", busy, 1);
      chk("R5 core_en low", core_en, 0);
      chk("R5 per_en low", per_en, 0);
      chk("R7 old mult kept", mult_sel, 0);
      e0 = ext_clk;
      @(negedge clk);
      chk("R6 ext toggles in stall", ext_clk, !e0);
      frq_we = 1'b1; frq_wdata = 7'h00;
      tmr_we = 1'b1; tmr_sel = 3'd7; tmr_load = 8'h10;
      @(negedge clk);
      frq_we = 1'b0; tmr_we = 1'b0;
      count_stall(n);
      chk("R9 R4 stall length unaffected", n + 2, 4);
      chk("R9 R7 selects from first write", sel_word(), 7'h2B);
      chk("R8 count zero after overflow", cnt, 0);
      chk("R3 core_en restarts after release", core_en, 1);
      @(negedge clk);
      chk("R8 count stays stopped", cnt, 0);
      chk("R12 busy low", busy, 0);

      // R4 prescaler k=2, L=FF: 8 * 1 = 8 cycles
      load_tmr(3'd2, 8'hFF);
      write_frq(7'h03);
      count_stall(n);
      chk("R4 prescaled stall length", n, 8);
      chk("R7 selects after prescaled wait", sel_word(), 7'h03);

      // R10 error set then cleared by accepted write
      write_frq(7'h08);
      chk("R10 err set", err, 1);
      chk("R10 no stall on bad write", stall, 0);
      chk("R10 selects unchanged", sel_word(), 7'h03);
      write_frq(7'h04);
      chk("R10 err cleared", err, 0);
      chk("R10 R3 new selects", sel_word(), 7'h04);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule